// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the software-visible register file of a multichannel DMA engine. A simple 32-bit register bus (write strobe, read strobe, word address, data) reaches a small global area and a row of per-pair windows. Each window serves one channel pair: a receive channel (even channel number, device to memory) and a transmit channel (odd channel number, memory to device). The receive registers begin at the start of the window. The transmit registers begin 0x18 bytes into it.

For every channel the bank holds the descriptor-list address as a high and a low word, plus two length settings. Receive channels also hold a bytes-per-row value and a run bit. The bank exports these values to the channel engines, together with one-cycle start and abort strobes. A global address-mode bit is exported to the engines as well.

Channel engines report completion with one-cycle done pulses. These set bits in a sticky status register that software clears by writing 1s. An enable mask filters the status into a pending register, and a single level interrupt is raised whenever any pending bit is set. Descriptor fetching and data movement live in the channel engines, outside this block.

Top module: `dma_ctl_regbank`

## Requirements
- R1: After reset, every stored register reads 0. The outputs `irq`, `addr32`, `ch_start`, `ch_abort` and `rx_run` are all 0.
- R2: Channel pair n has its window at byte address n*0x40. The receive registers sit at these window offsets: address high 0x00, address low 0x04, length 0x0C, block length 0x10, run 0x14 (bit 0) and bytes-per-row 0x30. The transmit registers sit at: address high 0x18, address low 0x1C, block length 0x24, length 0x2C. Each of these reads back the last value written and drives the matching configuration output of channel 2n (receive) or 2n+1 (transmit).
- R3: The address-mode register at 0x34 stores bit 0 only, reads back as that bit, and drives `addr32`.
- R4: A write to a transmit channel's address-low register raises that channel's `ch_start` bit for exactly the one cycle after the write. Writes to other transmit registers raise no start.
- R5: Writing 1 to the receive run bit while it is 0 raises that channel's `ch_start` bit for one cycle. Writing 0 while it is 1 raises its `ch_abort` bit for one cycle. Writing the value the bit already holds raises neither strobe.
- R6: A one-cycle pulse on `ch_done[i]` sets bit i of the interrupt status register at 0x080000. The bit stays set until software clears it.
- R7: Writing the status register clears every bit written as 1 and leaves every bit written as 0 unchanged. Writing all ones clears the whole register.
- R8: When a done pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: The pending register at 0x080004 reads as status AND enable, where enable is the register at 0x080008. Writes to the pending register have no effect.
- R10: `irq` is high exactly when some pending bit is set. With enable equal to 0, `irq` stays low whatever the status.
- R11: Reads of unmapped addresses return 0. This covers unused window offsets, windows beyond the last pair, and other global addresses. Writes to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, registered, valid the cycle after `bus_rd` |
| ch_done | input | 2*NUM_PAIRS | Per-channel completion pulses |
| irq | output | 1 | Level interrupt |
| addr32 | output | 1 | Address-mode bit |
| ch_start | output | 2*NUM_PAIRS | One-cycle start strobes |
| ch_abort | output | 2*NUM_PAIRS | One-cycle abort strobes (receive channels only) |
| ch_desc_hi | output | 2*NUM_PAIRS*DW | Descriptor address high word per channel |
| ch_desc_lo | output | 2*NUM_PAIRS*DW | Descriptor address low word per channel |
| ch_len | output | 2*NUM_PAIRS*DW | Length setting per channel |
| ch_blk_len | output | 2*NUM_PAIRS*DW | Block length setting per channel |
| rx_row_bytes | output | NUM_PAIRS*DW | Bytes-per-row per receive channel |
| rx_run | output | NUM_PAIRS | Receive run bit per pair |

## Verification
The hardest situation to reach from the ports is a done pulse landing on a status bit in the very cycle that a write-1-to-clear of that bit is captured. The bench drives the done input and the write strobe from the same falling edge, so both are sampled at one rising edge, and then reads the bit back. Unmapped writes are proved harmless by reading back the neighbouring mapped registers they could have hit if decode were wrong. Start and abort strobes are sampled in the single cycle they should be high, and again one cycle later.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;
   localparam int WIN_BITS = 6;
   // window offsets, receive side
   localparam logic [5:0] RX_DHI = 6'h00;
   localparam logic [5:0] RX_DLO = 6'h04;
   localparam logic [5:0] RX_LEN = 6'h0C;
   localparam logic [5:0] RX_BLK = 6'h10;
   localparam logic [5:0] RX_RUN = 6'h14;
   localparam logic [5:0] RX_ROW = 6'h30;
   // window offsets, transmit side (base 0x18)
   localparam logic [5:0] TX_BASE = 6'h18;
   localparam logic [5:0] TX_DHI = TX_BASE + 6'h00;
   localparam logic [5:0] TX_DLO = TX_BASE + 6'h04;
   localparam logic [5:0] TX_BLK = TX_BASE + 6'h0C;
   localparam logic [5:0] TX_LEN = TX_BASE + 6'h14;
   // global registers
   localparam int GL_AMODE = 'h34;
   localparam int GL_STS   = 'h80000;
   localparam int GL_PEND  = 'h80004;
   localparam int GL_IEN   = 'h80008;
endpackage

// File: rtl/dmarb_rx_regs.sv
module dmarb_rx_regs
   import dmarb_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [5:0]    off,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rd_data,
   output logic [DW-1:0] desc_hi,
   output logic [DW-1:0] desc_lo,
   output logic [DW-1:0] len,
   output logic [DW-1:0] blk,
   output logic [DW-1:0] row,
   output logic          run,
   output logic          start,
   output logic          abort
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         desc_hi <= '0;
         desc_lo <= '0;
         len     <= '0;
         blk     <= '0;
         row     <= '0;
         run     <= 1'b0;
         start   <= 1'b0;
         abort   <= 1'b0;
      end else begin
         start <= 1'b0;
         abort <= 1'b0;
         if (we) begin
            case (off)
               RX_DHI: desc_hi <= wdata;
               RX_DLO: desc_lo <= wdata;
               RX_LEN: len     <= wdata;
               RX_BLK: blk     <= wdata;
               RX_ROW: row     <= wdata;
               RX_RUN: begin
                  run   <= wdata[0];
                  start <= wdata[0] & ~run;
                  abort <= ~wdata[0] & run;
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (off)
         RX_DHI:  rd_data = desc_hi;
         RX_DLO:  rd_data = desc_lo;
         RX_LEN:  rd_data = len;
         RX_BLK:  rd_data = blk;
         RX_ROW:  rd_data = row;
         RX_RUN:  rd_data = {{(DW-1){1'b0}}, run};
         default: rd_data = '0;
      endcase
   end

   // R5: strobes never coincide, and a start leaves the channel running
   a_r5_start_abort_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(start && abort));
   a_r5_start_sets_run: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> run);
endmodule

// File: rtl/dmarb_tx_regs.sv
module dmarb_tx_regs
   import dmarb_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [5:0]    off,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rd_data,
   output logic [DW-1:0] desc_hi,
   output logic [DW-1:0] desc_lo,
   output logic [DW-1:0] len,
   output logic [DW-1:0] blk,
   output logic          start
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         desc_hi <= '0;
         desc_lo <= '0;
         len     <= '0;
         blk     <= '0;
         start   <= 1'b0;
      end else begin
         start <= we && (off == TX_DLO);
         if (we) begin
            case (off)
               TX_DHI: desc_hi <= wdata;
               TX_DLO: desc_lo <= wdata;
               TX_BLK: blk     <= wdata;
               TX_LEN: len     <= wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (off)
         TX_DHI:  rd_data = desc_hi;
         TX_DLO:  rd_data = desc_lo;
         TX_BLK:  rd_data = blk;
         TX_LEN:  rd_data = len;
         default: rd_data = '0;
      endcase
   end

   // R4: a start strobe always follows a write of the address-low register
   a_r4_start_after_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> $past(we && (off == TX_DLO)));
endmodule

// File: rtl/dmarb_irq.sv
module dmarb_irq #(
   parameter int NCH = 8,
   parameter int DW  = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] done,
   input  logic           sts_we,
   input  logic           ien_we,
   input  logic [DW-1:0]  wdata,
   output logic [NCH-1:0] sts,
   output logic [NCH-1:0] ien,
   output logic [NCH-1:0] pend,
   output logic           irq
);
   logic [NCH-1:0] clr;
   assign clr = sts_we ? wdata[NCH-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts <= '0;
         ien <= '0;
      end else begin
         sts <= (sts & ~clr) | done;
         if (ien_we) ien <= wdata[NCH-1:0];
      end
   end

   assign pend = sts & ien;
   assign irq  = |pend;

   // R6: a status bit only rises on a done pulse
   a_r6_rise_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((sts & ~$past(sts) & ~$past(done)) == '0));
   // R8: done beats a simultaneous clear
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|done) |=> ((sts & $past(done)) == $past(done)));
   // R7: bits written as 1 are gone unless a done hit them
   a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      sts_we |=> ((sts & $past(wdata[NCH-1:0]) & ~$past(done)) == '0));
endmodule

// File: rtl/dma_ctl_regbank.sv
module dma_ctl_regbank
   import dmarb_pkg::*;
#(
   parameter int NUM_PAIRS = 4,
   parameter int ADDR_W    = 20,
   parameter int DW        = 32,
   localparam int NCH      = 2 * NUM_PAIRS,
   localparam int PW       = ADDR_W - WIN_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DW-1:0]       bus_wdata,
   output logic [DW-1:0]       bus_rdata,
   input  logic [NCH-1:0]      ch_done,
   output logic                irq,
   output logic                addr32,
   output logic [NCH-1:0]      ch_start,
   output logic [NCH-1:0]      ch_abort,
   output logic [NCH*DW-1:0]   ch_desc_hi,
   output logic [NCH*DW-1:0]   ch_desc_lo,
   output logic [NCH*DW-1:0]   ch_len,
   output logic [NCH*DW-1:0]   ch_blk_len,
   output logic [NUM_PAIRS*DW-1:0] rx_row_bytes,
   output logic [NUM_PAIRS-1:0] rx_run
);
   generate
      if (NUM_PAIRS < 1 || NCH > DW) begin : g_bad_pairs
         $error("NUM_PAIRS must give between 2 and DW channels");
      end
      if (ADDR_W < 20) begin : g_bad_aw
         $error("ADDR_W too small for the interrupt registers");
      end
      if (DW < 8) begin : g_bad_dw
         $error("DW too small");
      end
   endgenerate

   logic [PW-1:0]  pair_idx;
   logic [5:0]     win_off;
   logic           in_win;
   logic           hit_amode, hit_sts, hit_pend, hit_ien;
   logic [DW-1:0]  rx_rd [NUM_PAIRS];
   logic [DW-1:0]  tx_rd [NUM_PAIRS];
   logic [NCH-1:0] sts, ien, pend;
   logic [DW-1:0]  rd_next;

   assign pair_idx  = bus_addr[ADDR_W-1:WIN_BITS];
   assign win_off   = bus_addr[WIN_BITS-1:0];
   assign in_win    = (pair_idx < PW'(NUM_PAIRS));
   assign hit_amode = (bus_addr == ADDR_W'(GL_AMODE));
   assign hit_sts   = (bus_addr == ADDR_W'(GL_STS));
   assign hit_pend  = (bus_addr == ADDR_W'(GL_PEND));
   assign hit_ien   = (bus_addr == ADDR_W'(GL_IEN));

   always_ff @(posedge clk) begin
      if (!rst_n)                   addr32 <= 1'b0;
      else if (bus_wr && hit_amode) addr32 <= bus_wdata[0];
   end

   dmarb_irq #(.NCH(NCH), .DW(DW)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .done   (ch_done),
      .sts_we (bus_wr && hit_sts),
      .ien_we (bus_wr && hit_ien),
      .wdata  (bus_wdata),
      .sts    (sts),
      .ien    (ien),
      .pend   (pend),
      .irq    (irq)
   );

   for (genvar n = 0; n < NUM_PAIRS; n++) begin : g_pair
      logic pwe;
      assign pwe = bus_wr && in_win && (pair_idx == PW'(n));

      dmarb_rx_regs #(.DW(DW)) u_rx (
         .clk     (clk),
         .rst_n   (rst_n),
         .we      (pwe),
         .off     (win_off),
         .wdata   (bus_wdata),
         .rd_data (rx_rd[n]),
         .desc_hi (ch_desc_hi[(2*n)*DW +: DW]),
         .desc_lo (ch_desc_lo[(2*n)*DW +: DW]),
         .len     (ch_len[(2*n)*DW +: DW]),
         .blk     (ch_blk_len[(2*n)*DW +: DW]),
         .row     (rx_row_bytes[n*DW +: DW]),
         .run     (rx_run[n]),
         .start   (ch_start[2*n]),
         .abort   (ch_abort[2*n])
      );

      dmarb_tx_regs #(.DW(DW)) u_tx (
         .clk     (clk),
         .rst_n   (rst_n),
         .we      (pwe),
         .off     (win_off),
         .wdata   (bus_wdata),
         .rd_data (tx_rd[n]),
         .desc_hi (ch_desc_hi[(2*n+1)*DW +: DW]),
         .desc_lo (ch_desc_lo[(2*n+1)*DW +: DW]),
         .len     (ch_len[(2*n+1)*DW +: DW]),
         .blk     (ch_blk_len[(2*n+1)*DW +: DW]),
         .start   (ch_start[2*n+1])
      );
      assign ch_abort[2*n+1] = 1'b0;
   end

   always_comb begin
      rd_next = '0;
      for (int n = 0; n < NUM_PAIRS; n++) begin
         if (in_win && pair_idx == PW'(n)) rd_next = rd_next | rx_rd[n] | tx_rd[n];
      end
      if (hit_amode) rd_next = {{(DW-1){1'b0}}, addr32};
      if (hit_sts)   rd_next = DW'(sts);
      if (hit_pend)  rd_next = DW'(pend);
      if (hit_ien)   rd_next = DW'(ien);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_next;
   end

   // R10: enable cleared means no interrupt
   a_r10_mask_all: assert property (@(posedge clk) disable iff (!rst_n)
      (ien == '0) |-> !irq);
endmodule

// File: tb/dma_ctl_regbank_tb.sv
`timescale 1ns/1ps
module dma_ctl_regbank_tb;
   localparam int NP  = 4;
   localparam int NCH = 2 * NP;
   localparam int AW  = 20;
   localparam int DW  = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [NCH-1:0] ch_done = '0;
   logic irq, addr32;
   logic [NCH-1:0] ch_start, ch_abort;
   logic [NCH*DW-1:0] ch_desc_hi, ch_desc_lo, ch_len, ch_blk_len;
   logic [NP*DW-1:0] rx_row_bytes;
   logic [NP-1:0] rx_run;

   int n_tests = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   dma_ctl_regbank #(.NUM_PAIRS(NP), .ADDR_W(AW), .DW(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ch_done(ch_done), .irq(irq), .addr32(addr32),
      .ch_start(ch_start), .ch_abort(ch_abort),
      .ch_desc_hi(ch_desc_hi), .ch_desc_lo(ch_desc_lo),
      .ch_len(ch_len), .ch_blk_len(ch_blk_len),
      .rx_row_bytes(rx_row_bytes), .rx_run(rx_run)
   );

   typedef struct packed {
      logic          wr;
      logic [19:0]   addr;
      logic [31:0]   data;
   } vec_t;

   localparam int NV = 28;
   // wr=1: write data; wr=0: read and expect data
   localparam vec_t VEC [NV] = '{
      '{1'b1, 20'h00000, 32'h11111111},  // R2 pair0 rx addr high
      '{1'b1, 20'h00004, 32'h22222224},  // R2 pair0 rx addr low
      '{1'b1, 20'h0000C, 32'h00000100},  // R2 pair0 rx length
      '{1'b1, 20'h00010, 32'h00000040},  // R2 pair0 rx block length
      '{1'b1, 20'h00030, 32'h00000280},  // R2 pair0 rx bytes per row
      '{1'b1, 20'h00058, 32'hAAAA0001},  // R2 pair1 tx addr high
      '{1'b1, 20'h0005C, 32'hBBBB0004},  // R2 pair1 tx addr low
      '{1'b1, 20'h00064, 32'h00000200},  // R2 pair1 tx block length
      '{1'b1, 20'h0006C, 32'h00000400},  // R2 pair1 tx length
      '{1'b1, 20'h000C8, 32'hFFFFFFFF},  // R11 unused offset in pair3
      '{1'b1, 20'h00100, 32'hDEADBEEF},  // R11 window past last pair
      '{1'b1, 20'h00034, 32'hFFFFFFFF},  // R3 address mode
      '{1'b0, 20'h00000, 32'h11111111},
      '{1'b0, 20'h00004, 32'h22222224},
      '{1'b0, 20'h0000C, 32'h00000100},
      '{1'b0, 20'h00010, 32'h00000040},
      '{1'b0, 20'h00030, 32'h00000280},
      '{1'b0, 20'h00058, 32'hAAAA0001},
      '{1'b0, 20'h0005C, 32'hBBBB0004},
      '{1'b0, 20'h00064, 32'h00000200},
      '{1'b0, 20'h0006C, 32'h00000400},
      '{1'b0, 20'h000C8, 32'h00000000},  // R11 unmapped reads 0
      '{1'b0, 20'h00100, 32'h00000000},
      '{1'b0, 20'h00034, 32'h00000001},  // R3 only bit 0
      '{1'b0, 20'h000C0, 32'h00000000},  // R11 neighbours untouched
      '{1'b0, 20'h000CC, 32'h00000000},
      '{1'b0, 20'h00040, 32'h00000000},
      '{1'b0, 20'h00018, 32'h00000000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic pulse_done(input logic [NCH-1:0] m);
      @(negedge clk);
      ch_done = m;
      @(negedge clk);
      ch_done = '0;
   endtask

   initial begin
      #(20 * 100000);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", 32'(irq), 0);
      chk("R1 addr32", 32'(addr32), 0);
      chk("R1 start", 32'(ch_start), 0);
      chk("R1 abort", 32'(ch_abort), 0);
      chk("R1 run", 32'(rx_run), 0);
      rd(20'h80000, v); chk("R1 status", v, 0);
      rd(20'h00004, v); chk("R1 rx addr low", v, 0);

      // R2 R3 R11 table walk
      for (int i = 0; i < NV; i++) begin
         if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
         else begin
            rd(VEC[i].addr, v);
            chk($sformatf("R2/R3/R11 row %0d", i), v, VEC[i].data);
         end
      end
      // R2 exported configuration
      chk("R2 desc hi ch0", ch_desc_hi[0 +: 32], 32'h11111111);
      chk("R2 desc lo ch3", ch_desc_lo[3*32 +: 32], 32'hBBBB0004);
      chk("R2 len ch3", ch_len[3*32 +: 32], 32'h400);
      chk("R2 blk ch0", ch_blk_len[0 +: 32], 32'h40);
      chk("R2 row pair0", rx_row_bytes[0 +: 32], 32'h280);
      chk("R3 addr32", 32'(addr32), 1);

      // R4 transmit start on address-low write (pair2 -> ch5)
      wr(20'h0009C, 32'h1000);
      chk("R4 tx start", 32'(ch_start), 32'h20);
      @(negedge clk);
      chk("R4 start one cycle", 32'(ch_start), 0);
      wr(20'h00098, 32'h1);
      chk("R4 no start on high write", 32'(ch_start), 0);

      // R5 receive run start/abort (pair2 -> ch4)
      wr(20'h00094, 32'h1);
      chk("R5 rx start", 32'(ch_start), 32'h10);
      chk("R5 no abort", 32'(ch_abort), 0);
      chk("R5 run set", 32'(rx_run), 32'h4);
      wr(20'h00094, 32'h1);
      chk("R5 rewrite 1 no start", 32'(ch_start), 0);
      wr(20'h00094, 32'h0);
      chk("R5 abort", 32'(ch_abort), 32'h10);
      chk("R5 no start on clear", 32'(ch_start), 0);
      chk("R5 run clear", 32'(rx_run), 0);
      wr(20'h00094, 32'h0);
      chk("R5 rewrite 0 no abort", 32'(ch_abort), 0);

      // R6 done sets status; R10 masked while enable is 0
      pulse_done(8'h08);
      rd(20'h80000, v); chk("R6 status set", v, 32'h08);
      chk("R10 masked irq", 32'(irq), 0);

      // R9 pending = status & enable, read-only
      wr(20'h80008, 32'h0C);
      rd(20'h80004, v); chk("R9 pending", v, 32'h08);
      chk("R10 irq high", 32'(irq), 1);
      wr(20'h80004, 32'hFF);
      rd(20'h80004, v); chk("R9 pending read-only", v, 32'h08);
      rd(20'h80008, v); chk("R9 enable readback", v, 32'h0C);

      // R7 write-1-to-clear
      pulse_done(8'h21);
      rd(20'h80000, v); chk("R6 status accumulate", v, 32'h29);
      wr(20'h80000, 32'h01);
      rd(20'h80000, v); chk("R7 clear one bit", v, 32'h28);
      wr(20'h80000, 32'h00);
      rd(20'h80000, v); chk("R7 zero write keeps", v, 32'h28);
      wr(20'h80000, 32'hFFFFFFFF);
      rd(20'h80000, v); chk("R7 clear all", v, 0);
      chk("R10 irq low after clear", 32'(irq), 0);

      // R8 set beats clear in the same cycle
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 20'h80000; bus_wdata = 32'h04; ch_done = 8'h04;
      @(negedge clk);
      bus_wr = 1'b0; ch_done = '0;
      rd(20'h80000, v); chk("R8 set wins", v, 32'h04);
      chk("R10 irq from bit2", 32'(irq), 1);
      wr(20'h80008, 32'h0);
      chk("R10 enable zero masks", 32'(irq), 0);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule